// File: doc/BRIEF.md
# Channel Status Presentation Sequencer

This block drives the inbound side of a parallel I/O channel handshake when a control unit has asked for service and the channel calls back. Once a device address and its status have been captured, the block raises the request tag. When the channel selects the unit without flagging an address transfer of its own, the block answers. It first places the device address on the inbound bus and walks the command-tag handshake. It then places the status byte on the bus and waits for the channel to accept, defer or cancel it.

Each wait point classifies the four outbound tags through a 16-entry decode table. The index is formed from address-out, operational-out, command-out and service-out. An internal Zero flag records whether a wait ended normally or was cut short by a selective reset or an interface disconnect. A one-cycle test state then routes the sequence on that flag. Every sequence ends with a single done pulse and a 2-bit outcome code. A normal end on a status that carries Device End also posts an end-of-selection notice with the device address. The sequencer does not wait for any acknowledge of that notice.

Top module: `stat_tag_seq`

## Requirements
- R1: After reset the inbound bus reads zero, and all inbound tags, done, the end-of-selection post, the chain output and the result code read 0.
- R2: A start pulse while idle captures address, status and nothing else. Request-in reads 1 from the next cycle on. A start pulse while a sequence is running is ignored.
- R3: While request-in is high, select with address-out low answers the call. From the next cycle the bus carries the device address, address-in and operational-in read 1, and request-in reads 0. Select with address-out high leaves the block waiting with request-in high.
- R4: After the answer, command-out rising drops address-in in the next cycle. Command-out then falling makes the bus carry the status, with status-in high, two cycles later.
- R5: The decode index is {address-out, operational-out, command-out, service-out}, with address-out at bit 3. Service-out with operational-out low is a selective reset. Address-out with operational-out high and command-out and service-out low is a disconnect. Service-out with operational-out high does not end an address-phase wait.
- R6: An abort code at any wait gives a done pulse two cycles later. The result is 2 for a selective reset and 3 for a disconnect. All inbound tags drop, and no status is presented after an address-phase abort.
- R7: Service-out with operational-out high while status is presented is a stack. Done pulses the next cycle with result 1, status-in drops, and request-in rises again. The retry presents the same address and status.
- R8: Command-out rising while status is presented samples the chain input. Once command-out and service-out are both low, done pulses two cycles later with result 0, and the chain output shows the sampled value.
- R9: On a normal end whose status has bit 2 (Device End) set, the end-of-selection post pulses with done and the bus address output carries the device address. No post occurs otherwise.
- R10: Done is high for exactly one cycle per outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture address and status and request service |
| dev_addr_i | input | DW | Device address to present |
| dev_stat_i | input | DW | Device status to present |
| chain_i | input | 1 | Chaining indication sampled on command acceptance |
| sel_i | input | 1 | Unit selected with valid address |
| tag_out_i | input | 4 | {address-out, operational-out, command-out, service-out} |
| bus_in_o | output | DW | Inbound data bus |
| req_in_o | output | 1 | Request-in tag |
| adr_in_o | output | 1 | Address-in tag |
| opl_in_o | output | 1 | Operational-in tag |
| sta_in_o | output | 1 | Status-in tag |
| done_o | output | 1 | One-cycle outcome strobe |
| result_o | output | 2 | 0 normal, 1 stacked, 2 selective reset, 3 disconnect |
| chain_o | output | 1 | Chain indication recorded in the status phase |
| eos_post_o | output | 1 | End-of-selection notice to the host |
| eos_addr_o | output | DW | Device address reported with the notice |

## Verification
Each stage of the handshake has a fixed latency. The answer to select, the address-in drop, and a stack outcome appear one cycle after the tag change that causes them. Status presentation, abort results and normal ends take two cycles, because of the Zero test state. The bench drives every tag change on a falling edge and samples one falling edge after each rising edge. It also checks that the intermediate cycle of each two-cycle path shows no outcome yet. Scenario vectors cover every abort point and both Device End settings, and they flip the chain input after it has been sampled.

// File: rtl/stat_tag_pkg.sv
package stat_tag_pkg;
   localparam int TAG_W  = 4;
   localparam int TG_ADR = 3;
   localparam int TG_OPL = 2;
   localparam int TG_CMD = 1;
   localparam int TG_SRV = 0;

   typedef enum logic [2:0] {TD_IDLE, TD_CMD, TD_SRV, TD_SELRES, TD_DISC} tag_dec_e;
   typedef enum logic [1:0] {RES_NORMAL = 2'd0, RES_STACK = 2'd1,
                             RES_SELRES = 2'd2, RES_DISC = 2'd3} res_e;
   typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADR_B, S_ADR_A,
                             S_TEST, S_STA_B, S_STA_A} st_e;

   function automatic tag_dec_e classify(input logic [TAG_W-1:0] t);
      tag_dec_e r;
      if (t[TG_SRV] && !t[TG_OPL])                              r = TD_SELRES;
      else if (t[TG_ADR] && t[TG_OPL] && !t[TG_CMD] && !t[TG_SRV]) r = TD_DISC;
      else if (t[TG_SRV])                                       r = TD_SRV;
      else if (t[TG_CMD])                                       r = TD_CMD;
      else                                                      r = TD_IDLE;
      return r;
   endfunction
endpackage

// File: rtl/stat_tag_dec.sv
module stat_tag_dec
   import stat_tag_pkg::*;
(
   input  logic [TAG_W-1:0] tag_i,
   output tag_dec_e         code_o
);
   localparam int TBL_N = 1 << TAG_W;

   tag_dec_e tbl [TBL_N];

   genvar g;
   generate
      for (g = 0; g < TBL_N; g++) begin : g_tbl
         assign tbl[g] = classify(TAG_W'(g));
      end
   endgenerate

   assign code_o = tbl[tag_i];
endmodule

// File: rtl/stat_tag_cap.sv
module stat_tag_cap #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] addr_i,
   input  logic [DW-1:0] stat_i,
   output logic [DW-1:0] addr_o,
   output logic [DW-1:0] stat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
         stat_o <= '0;
      end else if (load_i) begin
         addr_o <= addr_i;
         stat_o <= stat_i;
      end
   end
endmodule

// File: rtl/stat_tag_seq.sv
module stat_tag_seq
   import stat_tag_pkg::*;
#(
   parameter int DW     = 8,
   parameter int DE_BIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] dev_addr_i,
   input  logic [DW-1:0] dev_stat_i,
   input  logic          chain_i,
   input  logic          sel_i,
   input  logic [3:0]    tag_out_i,
   output logic [DW-1:0] bus_in_o,
   output logic          req_in_o,
   output logic          adr_in_o,
   output logic          opl_in_o,
   output logic          sta_in_o,
   output logic          done_o,
   output logic [1:0]    result_o,
   output logic          chain_o,
   output logic          eos_post_o,
   output logic [DW-1:0] eos_addr_o
);
   generate
      if (DE_BIT >= DW || DE_BIT < 0) begin : g_bad_de
         $error("DE_BIT must index the status byte");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   st_e           state;
   logic          zero_q, phase_sta_q, disc_q;
   logic [DW-1:0] cap_addr, cap_stat;
   tag_dec_e      dec;
   logic          cap_load, abort;

   assign cap_load = (state == S_IDLE) && start_i;
   assign abort    = (dec == TD_SELRES) || (dec == TD_DISC);

   stat_tag_cap #(.DW(DW)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cap_load),
      .addr_i (dev_addr_i),
      .stat_i (dev_stat_i),
      .addr_o (cap_addr),
      .stat_o (cap_stat)
   );

   stat_tag_dec u_dec (
      .tag_i  (tag_out_i),
      .code_o (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         zero_q      <= 1'b0;
         phase_sta_q <= 1'b0;
         disc_q      <= 1'b0;
         bus_in_o    <= '0;
         req_in_o    <= 1'b0;
         adr_in_o    <= 1'b0;
         opl_in_o    <= 1'b0;
         sta_in_o    <= 1'b0;
         done_o      <= 1'b0;
         result_o    <= RES_NORMAL;
         chain_o     <= 1'b0;
         eos_post_o  <= 1'b0;
      end else begin
         done_o     <= 1'b0;
         eos_post_o <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start_i) begin
                  req_in_o <= 1'b1;
                  chain_o  <= 1'b0;
                  state    <= S_REQ;
               end
            end
            S_REQ: begin
               if (sel_i && !tag_out_i[TG_ADR]) begin
                  bus_in_o <= cap_addr;
                  adr_in_o <= 1'b1;
                  opl_in_o <= 1'b1;
                  req_in_o <= 1'b0;
                  state    <= S_ADR_B;
               end
            end
            S_ADR_B: begin
               if (abort) begin
                  zero_q      <= 1'b0;
                  disc_q      <= (dec == TD_DISC);
                  phase_sta_q <= 1'b0;
                  state       <= S_TEST;
               end else if (dec == TD_CMD) begin
                  adr_in_o <= 1'b0;
                  zero_q   <= 1'b0;
                  state    <= S_ADR_A;
               end
            end
            S_ADR_A: begin
               if (abort) begin
                  zero_q      <= 1'b0;
                  disc_q      <= (dec == TD_DISC);
                  phase_sta_q <= 1'b0;
                  state       <= S_TEST;
               end else if (!tag_out_i[TG_CMD]) begin
                  zero_q      <= 1'b1;
                  phase_sta_q <= 1'b0;
                  state       <= S_TEST;
               end
            end
            S_TEST: begin
               if (zero_q && !phase_sta_q) begin
                  bus_in_o <= cap_stat;
                  sta_in_o <= 1'b1;
                  state    <= S_STA_B;
               end else begin
                  done_o     <= 1'b1;
                  result_o   <= zero_q ? RES_NORMAL : (disc_q ? RES_DISC : RES_SELRES);
                  eos_post_o <= zero_q && cap_stat[DE_BIT];
                  bus_in_o   <= '0;
                  adr_in_o   <= 1'b0;
                  opl_in_o   <= 1'b0;
                  sta_in_o   <= 1'b0;
                  state      <= S_IDLE;
               end
            end
            S_STA_B: begin
               if (abort) begin
                  zero_q      <= 1'b0;
                  disc_q      <= (dec == TD_DISC);
                  phase_sta_q <= 1'b1;
                  state       <= S_TEST;
               end else if (dec == TD_SRV) begin
                  done_o   <= 1'b1;
                  result_o <= RES_STACK;
                  bus_in_o <= '0;
                  opl_in_o <= 1'b0;
                  sta_in_o <= 1'b0;
                  req_in_o <= 1'b1;
                  state    <= S_REQ;
               end else if (dec == TD_CMD) begin
                  chain_o <= chain_i;
                  zero_q  <= 1'b0;
                  state   <= S_STA_A;
               end
            end
            S_STA_A: begin
               if (abort) begin
                  zero_q      <= 1'b0;
                  disc_q      <= (dec == TD_DISC);
                  phase_sta_q <= 1'b1;
                  state       <= S_TEST;
               end else if (!tag_out_i[TG_CMD] && !tag_out_i[TG_SRV]) begin
                  zero_q      <= 1'b1;
                  phase_sta_q <= 1'b1;
                  state       <= S_TEST;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign eos_addr_o = eos_post_o ? cap_addr : '0;
endmodule

// File: rtl/stat_tag_chk.sv
module stat_tag_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_i,
   input logic [3:0] tag_out_i,
   input logic       req_in_o,
   input logic       adr_in_o,
   input logic       opl_in_o,
   input logic       sta_in_o,
   input logic       done_o,
   input logic [1:0] result_o,
   input logic       eos_post_o
);
   // R4
   adr_sta_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(adr_in_o && sta_in_o));

   // R3
   req_opl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_in_o && opl_in_o));

   // R3
   adr_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in_o && sel_i && tag_out_i[3]) |=> (req_in_o && !adr_in_o));

   // R6
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!adr_in_o && !opl_in_o && !sta_in_o));

   // R9
   eos_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eos_post_o |-> (done_o && result_o == 2'd0));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind stat_tag_seq stat_tag_chk u_chk (.*);

// File: tb/stat_tag_seq_bench.sv
module stat_tag_seq_bench;
   localparam int DW = 8;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] s;
      logic       ch;
      logic [2:0] k;
      logic [1:0] r;
      logic       e;
   } vec_t;

   // kinds: 0 normal, 1 stack then retry, 2 selreset addr wait, 3 disconnect addr wait,
   //        4 selreset status wait, 5 disconnect status wait
   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{8'h11, 8'h04, 1'b0, 3'd0, 2'd0, 1'b1},
      '{8'h2A, 8'h80, 1'b1, 3'd0, 2'd0, 1'b0},
      '{8'h33, 8'h0C, 1'b0, 3'd1, 2'd0, 1'b1},
      '{8'h44, 8'h04, 1'b0, 3'd2, 2'd2, 1'b0},
      '{8'h55, 8'h04, 1'b0, 3'd3, 2'd3, 1'b0},
      '{8'h66, 8'h04, 1'b1, 3'd4, 2'd2, 1'b0},
      '{8'h77, 8'h04, 1'b1, 3'd5, 2'd3, 1'b0},
      '{8'hFE, 8'hFF, 1'b1, 3'd0, 2'd0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] dev_addr_i = '0;
   logic [DW-1:0] dev_stat_i = '0;
   logic          chain_i = 1'b0;
   logic          sel_i = 1'b0;
   logic [3:0]    tag_out_i = 4'b0000;
   logic [DW-1:0] bus_in_o;
   logic          req_in_o, adr_in_o, opl_in_o, sta_in_o, done_o, chain_o, eos_post_o;
   logic [1:0]    result_o;
   logic [DW-1:0] eos_addr_o;

   int  total = 0;
   int  bad = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   stat_tag_seq #(.DW(DW), .DE_BIT(2)) u_stat_tag_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_addr_i(dev_addr_i),
      .dev_stat_i(dev_stat_i), .chain_i(chain_i), .sel_i(sel_i), .tag_out_i(tag_out_i),
      .bus_in_o(bus_in_o), .req_in_o(req_in_o), .adr_in_o(adr_in_o), .opl_in_o(opl_in_o),
      .sta_in_o(sta_in_o), .done_o(done_o), .result_o(result_o), .chain_o(chain_o),
      .eos_post_o(eos_post_o), .eos_addr_o(eos_addr_o)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic answer(input vec_t v);
      sel_i = 1'b1; tag_out_i = 4'b0100;
      tick();
      sel_i = 1'b0;
      chk("R3 bus addr", 32'(bus_in_o), 32'(v.a));
      chk("R3 tags", {29'd0, adr_in_o, opl_in_o, req_in_o}, 32'b110);
   endtask

   task automatic run(input vec_t v);
      dev_addr_i = v.a; dev_stat_i = v.s; chain_i = v.ch; start_i = 1'b1;
      tick();
      start_i = 1'b0;
      chk("R2 req", 32'(req_in_o), 32'd1);
      answer(v);
      if (v.k == 3'd2) begin
         tag_out_i = 4'b0001;
         tick();
         chk("R6 no early done", 32'(done_o), 32'd0);
         tick();
      end else begin
         tag_out_i = 4'b0110;
         tick();
         chk("R4 adr drop", {30'd0, adr_in_o, opl_in_o}, 32'b01);
         if (v.k == 3'd3) begin
            tag_out_i = 4'b1100;
            tick(); tick();
         end else begin
            tag_out_i = 4'b0100;
            tick();
            chk("R4 test cycle", 32'(sta_in_o), 32'd0);
            tick();
            chk("R4 status", {23'd0, sta_in_o, bus_in_o}, {23'd0, 1'b1, v.s});
            if (v.k == 3'd1) begin
               tag_out_i = 4'b0101;
               tick();
               chk("R7 stack", {28'd0, done_o, result_o, req_in_o}, {28'd0, 1'b1, 2'd1, 1'b1});
               chk("R7 sta drop", 32'(sta_in_o), 32'd0);
               answer(v);
               tag_out_i = 4'b0110; tick();
               tag_out_i = 4'b0100; tick(); tick();
               chk("R7 retry status", 32'(bus_in_o), 32'(v.s));
            end
            if (v.k == 3'd4) begin
               tag_out_i = 4'b0001;
               tick(); tick();
            end else begin
               tag_out_i = 4'b0110;
               tick();
               chain_i = ~v.ch;
               if (v.k == 3'd5) begin
                  tag_out_i = 4'b1100;
                  tick(); tick();
               end else begin
                  tag_out_i = 4'b0100;
                  tick();
                  chk("R8 no early done", 32'(done_o), 32'd0);
                  tick();
                  chk("R8 chain", 32'(chain_o), 32'(v.ch));
               end
            end
         end
      end
      chk("R6 R8 done", {29'd0, done_o, result_o}, {29'd0, 1'b1, v.r});
      chk("R9 eos", 32'(eos_post_o), 32'(v.e));
      chk("R9 eos addr", 32'(eos_addr_o), v.e ? 32'(v.a) : 32'd0);
      chk("R6 tags low", {29'd0, adr_in_o, opl_in_o, sta_in_o}, 32'd0);
      tag_out_i = 4'b0000;
      tick();
      chk("R10 done once", 32'(done_o), 32'd0);
   endtask

   initial begin
      repeat (3) tick();
      chk("R1 reset tags", {26'd0, req_in_o, adr_in_o, opl_in_o, sta_in_o, done_o, eos_post_o}, 32'd0);
      chk("R1 reset bus", 32'(bus_in_o), 32'd0);
      chk("R1 reset result", {29'd0, chain_o, result_o}, 32'd0);
      rst_n = 1'b1;
      tick();
      for (int i = 0; i < NV; i++) run(VEC[i]);

      // directed: ignored start, select with address-out, service-out in address wait
      dev_addr_i = 8'h5A; dev_stat_i = 8'h04; start_i = 1'b1;
      tick();
      dev_addr_i = 8'h99; dev_stat_i = 8'h00;
      tick();
      start_i = 1'b0;
      chk("R2 req held", 32'(req_in_o), 32'd1);
      sel_i = 1'b1; tag_out_i = 4'b1100;
      tick();
      chk("R3 adr-out ignored", {30'd0, req_in_o, adr_in_o}, 32'b10);
      tag_out_i = 4'b0100;
      tick();
      sel_i = 1'b0;
      chk("R2 busy start ignored", 32'(bus_in_o), 32'h5A);
      tag_out_i = 4'b0101;
      tick();
      chk("R5 srv in addr wait", {30'd0, adr_in_o, done_o}, 32'b10);
      tag_out_i = 4'b0001;
      tick(); tick();
      chk("R5 selreset code", {29'd0, done_o, result_o}, {29'd0, 1'b1, 2'd2});
      tag_out_i = 4'b0000;
      tick();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule